// File: doc/BRIEF.md
# Glitch-free internal clock selector

This block builds one output clock from two internal oscillator sources. A 3-bit select code picks one of eight frequencies. Seven are power-of-two divisions of the high-frequency source, taken from a ripple-free postscaler counter. The eighth is the low-frequency source passed straight through. A control sequencer owns every change of selection. It runs on an always-on control clock, `ctl_clk`, which is the clock that software writes the select code on.

When the stored select code differs from the connected source, the sequencer first powers up the target oscillator if it was off. It then waits out a start-up count, measured in cycles of that oscillator. Next it disconnects the old source on one of that source's low phases and waits until every gate reports closed. Only then does it open the gate of the new source, which first passes a pulse on the new clock's next rising edge. The two stability flags and the reported active code change only in the cycle the switch completes. A new code written while a switch is under way is held, and it is acted on once the current switch completes.

Other consumers of the low-frequency source can keep its oscillator enabled through request inputs. A separate keep input holds the high-frequency oscillator on. Without that keep input, the high-frequency oscillator is released once the output has moved to the low-frequency source.

Top module: `intclk_switch`

## Requirements
- R1: After reset the stored select code and `active_sel` are 110, both stability flags are 0 and `lf_osc_en` is 0. With no write, the block then brings up the high-frequency oscillator and connects code 110, after which `hf_stable` is 1 and `lf_stable` is 0.
- R2: Code 000 connects the low-frequency source undivided. Code c from 001 to 111 connects the high-frequency source divided by 2^(7-c): 111 divides by 1, 110 by 2, 101 by 4, 100 by 8, 011 by 16, 010 by 32 and 001 by 64. Each output period equals the source period times that divisor.
- R3: When the target oscillator's enable was low at the time of the write, the switch completes no sooner than STARTUP_CYC target-oscillator periods after that enable rises.
- R4: A switch between two codes in 001 to 111 never lowers `hf_osc_en`, so it incurs no start-up wait.
- R5: `clk_out` never produces a high or low phase shorter than half a high-frequency period, and no two source gates are ever open together.
- R6: `lf_osc_en` is 1 while code 000 is connected or being switched to, while any bit of `lf_req` is 1, or while `dual_start` is 1 and the stored code is 000. Otherwise it is 0.
- R7: When a switch to code 000 completes with `hf_keep` at 0, `hf_osc_en` falls the next cycle. With `hf_keep` at 1 it stays 1.
- R8: `lf_stable` and `hf_stable` keep their values until a switch completes. At completion, a flag is 1 only if its oscillator is ready and is needed, either as the target or through its keep or request inputs.
- R9: A code written during a switch is held. After the running switch completes, the block switches to the last code written.
- R10: `active_sel` changes only when a switch completes, and then shows the code whose source is connected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Always-on control clock for the sequencer and the select register |
| hf_clk | input | 1 | High-frequency oscillator clock |
| lf_clk | input | 1 | Low-frequency oscillator clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each clock domain |
| sel_we | input | 1 | Write strobe for the select code (ctl_clk domain) |
| sel_wdata | input | 3 | Select code to store |
| lf_req | input | 3 | Keep-alive requests for the low-frequency oscillator from other consumers |
| dual_start | input | 1 | Two-speed start request; enables the low-frequency oscillator when the stored code is 000 |
| hf_keep | input | 1 | Holds the high-frequency oscillator enabled |
| clk_out | output | 1 | Selected output clock |
| lf_osc_en | output | 1 | Enable for the low-frequency oscillator |
| hf_osc_en | output | 1 | Enable for the high-frequency oscillator |
| lf_stable | output | 1 | Low-frequency source active and stable, updated at switch completion |
| hf_stable | output | 1 | High-frequency source active and stable, updated at switch completion |
| active_sel | output | 3 | Code of the source currently connected |

## Verification
`active_sel` and the two flags change in the same control cycle. The bench therefore polls them at every falling edge of `ctl_clk` and checks both the hold values before that cycle and the new values at it. A switch takes a variable time, which depends on start-up counts, synchronizer stages and the old clock's low phase. For that reason, no fixed latency is assumed for completion. Instead, start-up time is checked as a lower bound from the observed enable rise, and the output period is measured only after two rising output edges past completion.

The oscillator enables are registered one control cycle after their condition changes. Re-enabling also waits until the previous shutdown has been seen at the oscillator, so the bench checks them tens of cycles after a change in requests. Pulse widths are checked continuously by an edge monitor.

// File: rtl/intclk_pkg.sv
`timescale 1ns/1ps
// Shared types for the internal clock selector.
package intclk_pkg;
    // Sequencer phases: idle, target warm-up, old gate close, new gate open.
    typedef enum logic [1:0] {SQ_IDLE, SQ_WARM, SQ_DROP, SQ_CONN} sq_state_t;
endpackage

// File: rtl/intclk_sync2.sv
`timescale 1ns/1ps
// Two-flop synchronizer, one per bit, into the domain of clk.
// Assumes each bit of d is individually glitch-free (driven by a flop).
module intclk_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture and re-time the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/intclk_postscaler.sv
`timescale 1ns/1ps
// Binary postscaler on the high-frequency clock.
// taps[0] is the source itself; taps[k] is the source divided by 2^k with 50% duty.
// Assumes hf_clk runs during reset so the counter clears.
module intclk_postscaler #(
    parameter int STAGES = 6
) (
    input  logic          hf_clk,
    input  logic          rst_n,
    output logic [STAGES:0] taps
);
    logic [STAGES-1:0] cnt;

    // Free-running divide counter.
    always_ff @(posedge hf_clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    assign taps = {cnt, hf_clk};
endmodule

// File: rtl/intclk_gate_cell.sv
`timescale 1ns/1ps
// Glitch-free gate for one candidate clock.
// The request is synchronized on falling edges of clk_i. The gate enable changes only
// while src_i is low, so the gated output neither truncates a high phase nor starts mid-pulse.
// DIRECT=1: src_i is clk_i itself (low at every falling edge).
// DIRECT=0: src_i is a divided tap launched from clk_i; load only when the tap is low.
module intclk_gate_cell #(
    parameter bit DIRECT = 1'b1
) (
    input  logic clk_i,
    input  logic src_i,
    input  logic rst_n,
    input  logic req_i,
    output logic en_o,
    output logic gclk_o
);
    logic s1, s2;

    // Bring the control-domain request into this clock's falling-edge domain.
    always_ff @(negedge clk_i) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= req_i;
            s2 <= s1;
        end
    end

    generate
        if (DIRECT) begin : g_direct
            // Source is low at each falling edge: load freely.
            always_ff @(negedge clk_i) begin
                if (!rst_n) en_o <= 1'b0;
                else        en_o <= s2;
            end
        end else begin : g_tap
            // Load only during the tap's low phase.
            always_ff @(negedge clk_i) begin
                if (!rst_n)      en_o <= 1'b0;
                else if (!src_i) en_o <= s2;
            end
            // R5: the enable is frozen while the divided tap is high
            p_tap_low_load_r5: assert property (@(negedge clk_i) disable iff (!rst_n)
                src_i |=> (en_o == $past(en_o)));
        end
    endgenerate

    assign gclk_o = src_i & en_o;
endmodule

// File: rtl/intclk_warmup.sv
`timescale 1ns/1ps
// Start-up timer for one oscillator, clocked by that oscillator.
// ready_o rises after the synchronized enable has been high for STARTUP+1 cycles
// and clears one cycle after the synchronized enable falls.
module intclk_warmup #(
    parameter int STARTUP = 16
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic en_i,
    output logic ready_o
);
    localparam int CW = $clog2(STARTUP + 1);

    logic          en_s;
    logic [CW-1:0] cnt;

    intclk_sync2 #(.W(1)) u_en_sync (
        .clk   (osc_clk),
        .rst_n (rst_n),
        .d     (en_i),
        .q     (en_s)
    );

    // Count enabled cycles up to the start-up limit, then flag ready.
    always_ff @(posedge osc_clk) begin
        if (!rst_n || !en_s) begin
            cnt     <= '0;
            ready_o <= 1'b0;
        end else if (cnt == CW'(STARTUP)) begin
            ready_o <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3: ready never outlives the enable by more than one cycle
    p_ready_needs_en_r3: assert property (@(posedge osc_clk) disable iff (!rst_n)
        !en_s |=> !ready_o);
endmodule

// File: rtl/intclk_seq.sv
`timescale 1ns/1ps
// Switch sequencer in the control clock domain.
// Holds the select register, drives oscillator enables, requests source gates one at a
// time, and publishes the connected code and stability flags on switch completion.
// Assumes readiness and gate acknowledges arrive asynchronously from flops.
module intclk_seq
    import intclk_pkg::*;
#(
    parameter int NSRC       = 8,
    parameter int SEL_W      = 3,
    parameter int RESET_CODE = 6,
    parameter int LF_REQ_N   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_we,
    input  logic [SEL_W-1:0]    sel_wdata,
    input  logic [LF_REQ_N-1:0] lf_req,
    input  logic                dual_start,
    input  logic                hf_keep,
    input  logic                lf_rdy_a,
    input  logic                hf_rdy_a,
    input  logic [NSRC-1:0]     ack_a,
    output logic [NSRC-1:0]     gate_req,
    output logic                lf_en,
    output logic                hf_en,
    output logic                lf_stable,
    output logic                hf_stable,
    output logic [SEL_W-1:0]    active_sel
);
    localparam logic [SEL_W-1:0] LF_SEL  = '0;
    localparam logic [SEL_W-1:0] RST_SEL = SEL_W'(RESET_CODE);

    sq_state_t        state;
    logic [SEL_W-1:0] sel_reg, tgt;
    logic             cur_valid;
    logic             lf_rdy, hf_rdy;
    logic [NSRC-1:0]  ack;
    logic             busy, tgt_lf, cur_lf, lf_ext, lf_need, hf_need, tgt_ready;

    intclk_sync2 #(.W(NSRC + 2)) u_status_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({lf_rdy_a, hf_rdy_a, ack_a}),
        .q     ({lf_rdy, hf_rdy, ack})
    );

    // Decode which oscillators are needed and whether the target has warmed up.
    always_comb begin
        busy      = (state != SQ_IDLE);
        tgt_lf    = (tgt == LF_SEL);
        cur_lf    = (active_sel == LF_SEL);
        lf_ext    = (|lf_req) | (dual_start & (sel_reg == LF_SEL));
        lf_need   = (cur_valid & cur_lf) | (busy & tgt_lf) | lf_ext;
        hf_need   = (cur_valid & ~cur_lf) | (busy & ~tgt_lf) | hf_keep;
        tgt_ready = tgt_lf ? (lf_rdy & lf_en) : (hf_rdy & hf_en);
    end

    // Oscillator enables; a re-enable waits until the last shutdown was seen (ready low).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lf_en <= 1'b0;
            hf_en <= 1'b0;
        end else begin
            lf_en <= lf_need & (lf_en | ~lf_rdy);
            hf_en <= hf_need & (hf_en | ~hf_rdy);
        end
    end

    // Select register; writes land at any time and are picked up when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_reg <= RST_SEL;
        else if (sel_we) sel_reg <= sel_wdata;
    end

    // Switch sequence: warm target, close all gates, open target gate, publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            tgt        <= RST_SEL;
            active_sel <= RST_SEL;
            cur_valid  <= 1'b0;
            gate_req   <= '0;
            lf_stable  <= 1'b0;
            hf_stable  <= 1'b0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (!cur_valid || sel_reg != active_sel) begin
                        tgt   <= sel_reg;
                        state <= SQ_WARM;
                    end
                end
                SQ_WARM: begin
                    if (tgt_ready) begin
                        gate_req <= '0;
                        state    <= SQ_DROP;
                    end
                end
                SQ_DROP: begin
                    if (ack == '0) begin
                        gate_req <= NSRC'(1) << tgt;
                        state    <= SQ_CONN;
                    end
                end
                default: begin
                    if (ack[tgt]) begin
                        active_sel <= tgt;
                        cur_valid  <= 1'b1;
                        lf_stable  <= lf_rdy & (tgt_lf | lf_ext);
                        hf_stable  <= hf_rdy & (~tgt_lf | hf_keep);
                        state      <= SQ_IDLE;
                    end
                end
            endcase
        end
    end

    // R5: break-before-make, at most one gate acknowledges at a time
    p_single_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));

    // R10: when idle after a switch, the reported code's gate is the open one
    p_active_connected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE && cur_valid) |-> ack[active_sel]);

    // R8: flags move only in the completing phase
    p_flags_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_CONN) |=> $stable({lf_stable, hf_stable}));

    // R3: no gate handling before the target oscillator reports ready
    p_warm_before_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_DROP || state == SQ_CONN) |-> (tgt_lf ? lf_rdy : hf_rdy));

    // R7: released high-frequency oscillator once low-frequency is connected
    p_hf_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_IDLE && cur_valid && cur_lf && !hf_keep) |=> !hf_en);
endmodule

// File: rtl/intclk_switch.sv
`timescale 1ns/1ps
// Glitch-free internal clock selector (top).
// Eight candidate clocks: code 0 is the low-frequency source; code c>0 is the
// high-frequency source divided by 2^(NSRC-1-c). Each candidate has its own gate cell;
// the sequencer opens at most one gate, and clk_out is the OR of the gated clocks.
// Assumes all three clocks run while rst_n is low so every domain clears.
module intclk_switch #(
    parameter int POST_BITS   = 6,
    parameter int STARTUP_CYC = 16,
    parameter int LF_REQ_N    = 3
) (
    input  logic                ctl_clk,
    input  logic                hf_clk,
    input  logic                lf_clk,
    input  logic                rst_n,
    input  logic                sel_we,
    input  logic [2:0]          sel_wdata,
    input  logic [LF_REQ_N-1:0] lf_req,
    input  logic                dual_start,
    input  logic                hf_keep,
    output logic                clk_out,
    output logic                lf_osc_en,
    output logic                hf_osc_en,
    output logic                lf_stable,
    output logic                hf_stable,
    output logic [2:0]          active_sel
);
    localparam int NSRC       = POST_BITS + 2;
    localparam int SEL_W      = $clog2(NSRC);
    localparam int RESET_CODE = NSRC - 2;

    logic [POST_BITS:0] taps;
    logic [NSRC-1:0]    gate_req, gate_en, gclk;
    logic               lf_rdy, hf_rdy;

    intclk_postscaler #(.STAGES(POST_BITS)) u_post (
        .hf_clk (hf_clk),
        .rst_n  (rst_n),
        .taps   (taps)
    );

    intclk_warmup #(.STARTUP(STARTUP_CYC)) u_lf_warm (
        .osc_clk (lf_clk),
        .rst_n   (rst_n),
        .en_i    (lf_osc_en),
        .ready_o (lf_rdy)
    );

    intclk_warmup #(.STARTUP(STARTUP_CYC)) u_hf_warm (
        .osc_clk (hf_clk),
        .rst_n   (rst_n),
        .en_i    (hf_osc_en),
        .ready_o (hf_rdy)
    );

    // One gate cell per candidate: code 0 on the low-frequency clock, the rest on taps.
    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_src
            if (i == 0) begin : g_lf
                intclk_gate_cell #(.DIRECT(1'b1)) u_cell (
                    .clk_i  (lf_clk),
                    .src_i  (lf_clk),
                    .rst_n  (rst_n),
                    .req_i  (gate_req[i]),
                    .en_o   (gate_en[i]),
                    .gclk_o (gclk[i])
                );
            end else begin : g_hf
                localparam int TI = NSRC - 1 - i;
                intclk_gate_cell #(.DIRECT(TI == 0)) u_cell (
                    .clk_i  (hf_clk),
                    .src_i  (taps[TI]),
                    .rst_n  (rst_n),
                    .req_i  (gate_req[i]),
                    .en_o   (gate_en[i]),
                    .gclk_o (gclk[i])
                );
            end
        end
    endgenerate

    intclk_seq #(
        .NSRC       (NSRC),
        .SEL_W      (SEL_W),
        .RESET_CODE (RESET_CODE),
        .LF_REQ_N   (LF_REQ_N)
    ) u_seq (
        .clk        (ctl_clk),
        .rst_n      (rst_n),
        .sel_we     (sel_we),
        .sel_wdata  (sel_wdata),
        .lf_req     (lf_req),
        .dual_start (dual_start),
        .hf_keep    (hf_keep),
        .lf_rdy_a   (lf_rdy),
        .hf_rdy_a   (hf_rdy),
        .ack_a      (gate_en),
        .gate_req   (gate_req),
        .lf_en      (lf_osc_en),
        .hf_en      (hf_osc_en),
        .lf_stable  (lf_stable),
        .hf_stable  (hf_stable),
        .active_sel (active_sel)
    );

    assign clk_out = |gclk;
endmodule

// File: tb/intclk_switch_bench.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random code sequence.
module intclk_switch_bench;
    localparam int  STARTUP = 16;
    localparam real HF_P    = 7.0;
    localparam real LF_P    = 97.0;

    logic       ctl_clk = 1'b0, hf_clk = 1'b0, lf_clk = 1'b0;
    logic       rst_n = 1'b0, sel_we = 1'b0, dual_start = 1'b0, hf_keep = 1'b0;
    logic [2:0] sel_wdata = 3'd0, lf_req = 3'd0;
    logic       clk_out, lf_osc_en, hf_osc_en, lf_stable, hf_stable;
    logic [2:0] active_sel;

    int n_chk = 0, n_bad = 0;
    int pulse_bad = 0, pulse_cnt = 0;
    bit mon_on = 1'b0;
    real t_rise = 0.0, t_fall = 0.0;

    always #5    ctl_clk = ~ctl_clk;
    always #3.5  hf_clk  = ~hf_clk;
    always #48.5 lf_clk  = ~lf_clk;

    intclk_switch u_intclk_switch (
        .ctl_clk (ctl_clk), .hf_clk (hf_clk), .lf_clk (lf_clk), .rst_n (rst_n),
        .sel_we (sel_we), .sel_wdata (sel_wdata), .lf_req (lf_req),
        .dual_start (dual_start), .hf_keep (hf_keep), .clk_out (clk_out),
        .lf_osc_en (lf_osc_en), .hf_osc_en (hf_osc_en), .lf_stable (lf_stable),
        .hf_stable (hf_stable), .active_sel (active_sel)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic real exp_period(input int code);
        return (code == 0) ? LF_P : HF_P * real'(1 << (7 - code));
    endfunction

    function automatic real tgt_period(input int code);
        return (code == 0) ? LF_P : HF_P;
    endfunction

    // R5 monitor: every phase of clk_out is at least half an HF period
    always @(clk_out) begin
        if (mon_on) begin
            if (clk_out) begin
                if ($realtime - t_fall < HF_P / 2.0 - 0.01) pulse_bad++;
                t_rise = $realtime;
                pulse_cnt++;
            end else begin
                if ($realtime - t_rise < HF_P / 2.0 - 0.01) pulse_bad++;
                t_fall = $realtime;
            end
        end
    end

    task automatic meas_period(input int code, input string req);
        real t0, t1, e;
        @(posedge clk_out); @(posedge clk_out); t0 = $realtime;
        @(posedge clk_out); t1 = $realtime;
        e = exp_period(code);
        chk(((t1 - t0) > e - 0.01) && ((t1 - t0) < e + 0.01), req, "output period x10",
            int'((t1 - t0) * 10.0), int'(e * 10.0));
        @(negedge ctl_clk);
    endtask

    task automatic write_sel(input int code);
        sel_wdata = 3'(code);
        sel_we    = 1'b1;
        @(negedge ctl_clk);
        sel_we    = 1'b0;
    endtask

    // Full switch with R2/R3/R4/R7/R8/R10 checks
    task automatic do_switch(input int code);
        bit  was_off, tap2tap, hf_dropped, flags_held, done, en_seen;
        logic old_lf, old_hf, e_lf, e_hf;
        real t_en, t_done;
        was_off    = (code == 0) ? !lf_osc_en : !hf_osc_en;
        tap2tap    = (code != 0) && (active_sel != 3'd0);
        old_lf     = lf_stable;
        old_hf     = hf_stable;
        hf_dropped = 1'b0; flags_held = 1'b1; done = 1'b0; en_seen = 1'b0;
        t_en = $realtime; t_done = $realtime;
        write_sel(code);
        for (int k = 0; k < 6000 && !done; k++) begin
            if (active_sel == 3'(code)) begin
                done = 1'b1;
                t_done = $realtime;
            end else begin
                if (lf_stable !== old_lf || hf_stable !== old_hf) flags_held = 1'b0;
                if (tap2tap && !hf_osc_en) hf_dropped = 1'b1;
                if (was_off && !en_seen && ((code == 0) ? lf_osc_en : hf_osc_en)) begin
                    en_seen = 1'b1;
                    t_en = $realtime;
                end
                @(negedge ctl_clk);
            end
        end
        chk(done, "R10", "active_sel reaches target", int'(active_sel), code);
        chk(flags_held, "R8", "flags held during switch", int'({lf_stable, hf_stable}),
            int'({old_lf, old_hf}));
        e_lf = (code == 0) ? 1'b1 : 1'b0;
        e_hf = (code != 0) ? 1'b1 : hf_keep;
        chk(lf_stable == e_lf && hf_stable == e_hf, "R8", "flags at completion",
            int'({lf_stable, hf_stable}), int'({e_lf, e_hf}));
        if (was_off)
            chk(en_seen && (t_done - t_en) >= STARTUP * tgt_period(code), "R3",
                "start-up time x10", int'((t_done - t_en) * 10.0),
                int'(STARTUP * tgt_period(code) * 10.0));
        if (tap2tap)
            chk(!hf_dropped, "R4", "hf enable kept across tap switch", int'(hf_dropped), 0);
        if (code == 0) begin
            repeat (5) @(negedge ctl_clk);
            chk(hf_osc_en == hf_keep, "R7", "hf enable after LF connect",
                int'(hf_osc_en), int'(hf_keep));
        end
        meas_period(code, "R2");
    endtask

    // Watchdog: expiry counts as a failure and still reports
    initial begin
        #1_500_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cur, nxt;
        void'($urandom(32'd20240611));
        repeat (40) @(negedge ctl_clk);
        rst_n = 1'b1;
        @(negedge ctl_clk);
        mon_on = 1'b1;
        t_rise = $realtime; t_fall = $realtime;
        // R1: reset state
        chk(active_sel == 3'b110, "R1", "active_sel after reset", int'(active_sel), 6);
        chk(!lf_stable && !hf_stable, "R1", "flags after reset",
            int'({lf_stable, hf_stable}), 0);
        chk(!lf_osc_en, "R1", "lf enable after reset", int'(lf_osc_en), 0);
        begin
            bit up = 1'b0;
            for (int k = 0; k < 3000 && !up; k++) begin
                if (hf_stable) up = 1'b1; else @(negedge ctl_clk);
            end
            chk(up && !lf_stable && active_sel == 3'b110, "R1", "power-up connect",
                int'({hf_stable, lf_stable}), 2);
        end
        meas_period(6, "R1");

        // R6: LF enable conditions while HF selected
        repeat (40) @(negedge ctl_clk);
        chk(!lf_osc_en, "R6", "lf enable idle", int'(lf_osc_en), 0);
        for (int b = 0; b < 3; b++) begin
            lf_req = 3'(1 << b);
            repeat (60) @(negedge ctl_clk);
            chk(lf_osc_en, "R6", "lf enable on request bit", int'(lf_osc_en), 1);
            lf_req = 3'd0;
            repeat (60) @(negedge ctl_clk);
            chk(!lf_osc_en, "R6", "lf enable after request drop", int'(lf_osc_en), 0);
        end
        dual_start = 1'b1;
        repeat (60) @(negedge ctl_clk);
        chk(!lf_osc_en, "R6", "dual_start ignored for non-LF code", int'(lf_osc_en), 0);
        dual_start = 1'b0;

        // Directed: every code, tap-to-tap, to LF and back (R2, R3, R4, R7)
        do_switch(7); do_switch(1); do_switch(0); do_switch(5);
        do_switch(4); do_switch(3); do_switch(2); do_switch(0); do_switch(6);

        // R7: keep request holds HF on across LF connect
        hf_keep = 1'b1;
        do_switch(0);
        chk(hf_osc_en && hf_stable, "R7", "hf kept on with keep",
            int'({hf_osc_en, hf_stable}), 3);
        do_switch(3);
        hf_keep = 1'b0;

        // R9: write during a switch is held and applied next
        write_sel(0);
        repeat (3) @(negedge ctl_clk);
        write_sel(5);
        begin
            bit fin = 1'b0;
            for (int k = 0; k < 8000 && !fin; k++) begin
                if (active_sel == 3'd5) fin = 1'b1; else @(negedge ctl_clk);
            end
            chk(fin, "R9", "pending code applied", int'(active_sel), 5);
        end
        repeat (20) @(negedge ctl_clk);
        chk(active_sel == 3'd5, "R9", "pending code stays", int'(active_sel), 5);
        meas_period(5, "R9");

        // Random code sequence
        cur = 5;
        for (int n = 0; n < 20; n++) begin
            nxt = int'($urandom % 8);
            if (nxt == cur) nxt = (nxt + 1) % 8;
            do_switch(nxt);
            cur = nxt;
        end

        chk(pulse_bad == 0 && pulse_cnt > 0, "R5", "short output phases", pulse_bad, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule